// File: doc/BRIEF.md
# Host Command Packet Dispatcher

This block sits behind a byte-serial handshake engine. The engine presents one finished host packet at a time as a flat byte buffer with a length. The dispatcher reads the packet-type byte and acts on two kinds of packet.

A controller-command packet is checked against a per-command parameter count. It then either changes the block's own state or is refused with a typed error packet that echoes the offending command. In both cases the block builds a reply in an output buffer and raises a one-cycle ready strobe for the engine. A peripheral-bus packet is passed out through a simple request/response port, and the answer is wrapped into a reply when it returns.

The block keeps a 32-bit seconds counter that advances on a once-per-second tick and can be read or loaded by command. It holds the polling configuration: a 16-bit device mask, an autopoll enable and a poll interval. It also raises single-cycle power-down and system-reset requests. The command code values are parameters.

Top module: `pkt_dispatch`

## Requirements
- R1: After synchronous reset, `poll_mask` is 0xFFFF, `autopoll_en` is 0, `poll_rate` equals `DEFAULT_RATE` (20), the seconds counter is 0, and `rsp_valid` and `pb_req` are low.
- R2: A packet whose type byte (byte 0) is neither 0 (peripheral bus) nor 1 (controller command) is ignored: no reply, no bus request and no register change. A command packet shorter than 2 bytes is also ignored.
- R3: Byte i of every buffer sits at bits [8i+7:8i]. An accepted command packet (byte 1 = command code, bytes 2.. = parameters, parameter count = length - 2) produces a one-cycle `rsp_valid` in the cycle after `pkt_valid`. A successful reply is 1, 0, command code, then any result bytes, with `rsp_len` = 3 + result count.
- R4: An unrecognised command code yields the 4-byte reply 2, 2, 1, command code.
- R5: A command with the wrong parameter count yields the 4-byte reply 2, 5, 1, command code and changes no state. The required counts are: autopoll 1, poll rate 1, device mask 2, power-down 0, system reset 0, file-server flag 1, power messages 1, read time 0, set time 4.
- R6: The poll-rate command loads `poll_rate` from its parameter. A parameter of 0 is refused with the bad-parameter reply and leaves the rate unchanged.
- R7: The device-mask command sets `poll_mask` to {parameter 0, parameter 1}, so the first parameter is the high byte.
- R8: The autopoll command sets `autopoll_en` to 1 for a nonzero parameter and to 0 for a zero parameter.
- R9: The seconds counter adds 1 (wrapping modulo 2^32) on each `sec_tick` cycle. Set time loads the four parameters, most significant first, and a load wins over a tick in the same cycle. Read time returns the counter in four result bytes, most significant first.
- R10: A valid power-down or system-reset command pulses `pwr_down_req` or `sys_reset_req` for one cycle, in the same cycle as its success reply. A refused one pulses nothing.
- R11: The file-server-flag and power-messages commands are acknowledged with a 3-byte success reply and have no other effect.
- R12: A peripheral-bus packet of length L drives a one-cycle `pb_req` carrying bytes 1..L-1 and `pb_req_len` = L-1. On `pb_done` with `pb_status` 0 the reply is 0, 0, then `pb_rsp_len` response bytes. With a nonzero status the reply is 0, status, then the original byte 1 (3 bytes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Host packet present for one cycle |
| pkt_len | input | LW | Packet length in bytes |
| pkt_data | input | MAX_PKT*8 | Packet bytes, byte 0 in the low bits |
| sec_tick | input | 1 | One-cycle pulse per second |
| rsp_valid | output | 1 | Reply ready strobe |
| rsp_len | output | RLW | Reply length in bytes |
| rsp_data | output | MAX_RSP*8 | Reply bytes, byte 0 in the low bits |
| pb_req | output | 1 | Peripheral-bus request strobe |
| pb_req_len | output | LW | Forwarded byte count |
| pb_req_data | output | (MAX_PKT-1)*8 | Forwarded bytes |
| pb_done | input | 1 | Peripheral-bus answer strobe |
| pb_status | input | 8 | 0 for success, else error code |
| pb_rsp_len | input | RLW | Answer byte count |
| pb_rsp_data | input | (MAX_RSP-2)*8 | Answer bytes |
| poll_mask | output | 16 | Device poll mask |
| autopoll_en | output | 1 | Autopoll enable |
| poll_rate | output | 8 | Poll interval |
| pwr_down_req | output | 1 | Power-down request pulse |
| sys_reset_req | output | 1 | System-reset request pulse |

## Verification
The bench builds the block with its defaults: 8-byte packet and reply buffers, a default poll interval of 20 and the default command codes. With an 8-byte packet buffer, every command can be sent with one parameter too many. Set time can therefore be sent with five parameters, and the device mask with three. The 8-byte reply buffer holds the 7-byte read-time reply in full, and a bus answer of up to six bytes. Loading 0xFFFFFFFF and ticking once reaches the counter wrap without a long run.

// File: rtl/pkt_dispatch_pkg.sv
package pkt_dispatch_pkg;

    localparam logic [7:0] PT_BUS      = 8'd0;
    localparam logic [7:0] PT_CMD      = 8'd1;
    localparam logic [7:0] PT_ERR      = 8'd2;
    localparam logic [7:0] ERR_UNKNOWN = 8'd2;
    localparam logic [7:0] ERR_BADPARM = 8'd5;

    typedef enum logic [1:0] {
        VERD_OK      = 2'd0,
        VERD_UNKNOWN = 2'd1,
        VERD_BADPARM = 2'd2
    } verdict_e;

    typedef struct packed {
        logic autopoll;
        logic rate;
        logic mask;
        logic pwrdn;
        logic sysrst;
        logic settime;
        logic gettime;
    } action_t;

    function automatic logic [7:0] err_code(input verdict_e v);
        return (v == VERD_UNKNOWN) ? ERR_UNKNOWN : ERR_BADPARM;
    endfunction

endpackage

// File: rtl/pd_cmd_check.sv
module pd_cmd_check
    import pkt_dispatch_pkg::*;
#(
    parameter logic [7:0] CODE_AUTOPOLL = 8'h01,
    parameter logic [7:0] CODE_RATE     = 8'h14,
    parameter logic [7:0] CODE_MASK     = 8'h19,
    parameter logic [7:0] CODE_PWRDN    = 8'h0A,
    parameter logic [7:0] CODE_SYSRST   = 8'h11,
    parameter logic [7:0] CODE_FSFLAG   = 8'h13,
    parameter logic [7:0] CODE_PWRMSG   = 8'h21,
    parameter logic [7:0] CODE_GETTIME  = 8'h03,
    parameter logic [7:0] CODE_SETTIME  = 8'h09
) (
    input  logic [7:0] cmd_code,
    input  logic [7:0] n_param,
    input  logic [7:0] first_param,
    output verdict_e   verdict,
    output action_t    act
);

    always_comb begin
        act     = '0;
        verdict = VERD_OK;
        case (cmd_code)
            CODE_AUTOPOLL: if (n_param == 8'd1) act.autopoll = 1'b1;
                           else verdict = VERD_BADPARM;
            CODE_RATE:     if (n_param == 8'd1 && first_param != 8'd0) act.rate = 1'b1;
                           else verdict = VERD_BADPARM;
            CODE_MASK:     if (n_param == 8'd2) act.mask = 1'b1;
                           else verdict = VERD_BADPARM;
            CODE_PWRDN:    if (n_param == 8'd0) act.pwrdn = 1'b1;
                           else verdict = VERD_BADPARM;
            CODE_SYSRST:   if (n_param == 8'd0) act.sysrst = 1'b1;
                           else verdict = VERD_BADPARM;
            CODE_FSFLAG,
            CODE_PWRMSG:   if (n_param != 8'd1) verdict = VERD_BADPARM;
            CODE_GETTIME:  if (n_param == 8'd0) act.gettime = 1'b1;
                           else verdict = VERD_BADPARM;
            CODE_SETTIME:  if (n_param == 8'd4) act.settime = 1'b1;
                           else verdict = VERD_BADPARM;
            default:       verdict = VERD_UNKNOWN;
        endcase
    end

endmodule

// File: rtl/pd_rtc.sv
module pd_rtc #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (tick) count <= count + CW'(1);
    end

    // R9
    tick_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tick) && !$past(load)) |-> (count == $past(count) + CW'(1)));

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load)) |-> (count == $past(load_val)));

endmodule

// File: rtl/pd_cfg_regs.sv
module pd_cfg_regs #(
    parameter logic [7:0] DEFAULT_RATE = 8'd20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        do_autopoll,
    input  logic        do_rate,
    input  logic        do_mask,
    input  logic        do_pwrdn,
    input  logic        do_sysrst,
    input  logic [7:0]  p0,
    input  logic [7:0]  p1,
    output logic [15:0] poll_mask,
    output logic        autopoll_en,
    output logic [7:0]  poll_rate,
    output logic        pwr_down_req,
    output logic        sys_reset_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            poll_mask     <= 16'hFFFF;
            autopoll_en   <= 1'b0;
            poll_rate     <= DEFAULT_RATE;
            pwr_down_req  <= 1'b0;
            sys_reset_req <= 1'b0;
        end else begin
            if (do_mask)     poll_mask   <= {p0, p1};
            if (do_autopoll) autopoll_en <= (p0 != 8'd0);
            if (do_rate)     poll_rate   <= p0;
            pwr_down_req  <= do_pwrdn;
            sys_reset_req <= do_sysrst;
        end
    end

    // R6
    rate_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        poll_rate != 8'd0);

    // R10
    one_request_chk: assert property (@(posedge clk) disable iff (rst)
        !(pwr_down_req && sys_reset_req));

endmodule

// File: rtl/pkt_dispatch.sv
module pkt_dispatch
    import pkt_dispatch_pkg::*;
#(
    parameter int         MAX_PKT       = 8,
    parameter int         MAX_RSP       = 8,
    parameter logic [7:0] DEFAULT_RATE  = 8'd20,
    parameter logic [7:0] CODE_AUTOPOLL = 8'h01,
    parameter logic [7:0] CODE_RATE     = 8'h14,
    parameter logic [7:0] CODE_MASK     = 8'h19,
    parameter logic [7:0] CODE_PWRDN    = 8'h0A,
    parameter logic [7:0] CODE_SYSRST   = 8'h11,
    parameter logic [7:0] CODE_FSFLAG   = 8'h13,
    parameter logic [7:0] CODE_PWRMSG   = 8'h21,
    parameter logic [7:0] CODE_GETTIME  = 8'h03,
    parameter logic [7:0] CODE_SETTIME  = 8'h09,
    localparam int        LW            = $clog2(MAX_PKT + 1),
    localparam int        RLW           = $clog2(MAX_RSP + 1),
    localparam int        PBW           = MAX_RSP - 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pkt_valid,
    input  logic [LW-1:0]          pkt_len,
    input  logic [MAX_PKT*8-1:0]   pkt_data,
    input  logic                   sec_tick,
    output logic                   rsp_valid,
    output logic [RLW-1:0]         rsp_len,
    output logic [MAX_RSP*8-1:0]   rsp_data,
    output logic                   pb_req,
    output logic [LW-1:0]          pb_req_len,
    output logic [(MAX_PKT-1)*8-1:0] pb_req_data,
    input  logic                   pb_done,
    input  logic [7:0]             pb_status,
    input  logic [RLW-1:0]         pb_rsp_len,
    input  logic [PBW*8-1:0]       pb_rsp_data,
    output logic [15:0]            poll_mask,
    output logic                   autopoll_en,
    output logic [7:0]             poll_rate,
    output logic                   pwr_down_req,
    output logic                   sys_reset_req
);

    logic [7:0] pkt_type, cmd_code, p0, p1, p2, p3, n_param, first_b;
    assign pkt_type = pkt_data[7:0];
    assign cmd_code = pkt_data[15:8];
    assign p0       = pkt_data[23:16];
    assign p1       = pkt_data[31:24];
    assign p2       = pkt_data[39:32];
    assign p3       = pkt_data[47:40];
    assign n_param  = 8'(pkt_len - LW'(2));

    logic wait_pb, accept, is_bus, is_cmd, bus_fire;
    assign accept   = pkt_valid && !wait_pb;
    assign is_bus   = accept && (pkt_len >= LW'(1)) && (pkt_type == PT_BUS);
    assign is_cmd   = accept && (pkt_len >= LW'(2)) && (pkt_type == PT_CMD);
    assign bus_fire = wait_pb && pb_done;

    verdict_e verdict;
    action_t  act, act_g;

    pd_cmd_check #(
        .CODE_AUTOPOLL(CODE_AUTOPOLL), .CODE_RATE(CODE_RATE), .CODE_MASK(CODE_MASK),
        .CODE_PWRDN(CODE_PWRDN), .CODE_SYSRST(CODE_SYSRST), .CODE_FSFLAG(CODE_FSFLAG),
        .CODE_PWRMSG(CODE_PWRMSG), .CODE_GETTIME(CODE_GETTIME), .CODE_SETTIME(CODE_SETTIME)
    ) u_check (
        .cmd_code(cmd_code), .n_param(n_param), .first_param(p0),
        .verdict(verdict), .act(act)
    );

    assign act_g = (is_cmd && verdict == VERD_OK) ? act : '0;

    logic [31:0] seconds;

    pd_rtc #(.CW(32)) u_rtc (
        .clk(clk), .rst(rst), .tick(sec_tick), .load(act_g.settime),
        .load_val({p0, p1, p2, p3}), .count(seconds)
    );

    pd_cfg_regs #(.DEFAULT_RATE(DEFAULT_RATE)) u_cfg (
        .clk(clk), .rst(rst),
        .do_autopoll(act_g.autopoll), .do_rate(act_g.rate), .do_mask(act_g.mask),
        .do_pwrdn(act_g.pwrdn), .do_sysrst(act_g.sysrst),
        .p0(p0), .p1(p1),
        .poll_mask(poll_mask), .autopoll_en(autopoll_en), .poll_rate(poll_rate),
        .pwr_down_req(pwr_down_req), .sys_reset_req(sys_reset_req)
    );

    // Command reply image
    logic [MAX_RSP*8-1:0] cmd_rsp;
    logic [RLW-1:0]       cmd_len;
    always_comb begin
        cmd_rsp = '0;
        if (verdict == VERD_OK) begin
            cmd_rsp[23:0] = {cmd_code, 8'h00, PT_CMD};
            cmd_len       = RLW'(3);
            if (act.gettime) begin
                cmd_rsp[55:24] = {seconds[7:0], seconds[15:8], seconds[23:16], seconds[31:24]};
                cmd_len        = RLW'(7);
            end
        end else begin
            cmd_rsp[31:0] = {cmd_code, PT_CMD, err_code(verdict), PT_ERR};
            cmd_len       = RLW'(4);
        end
    end

    // Peripheral-bus reply image
    logic [MAX_RSP*8-1:0] bus_rsp;
    logic [RLW-1:0]       bus_len, pb_n;
    assign pb_n = (pb_rsp_len > RLW'(PBW)) ? RLW'(PBW) : pb_rsp_len;
    always_comb begin
        if (pb_status == 8'd0) begin
            bus_rsp = {pb_rsp_data, 8'h00, PT_BUS};
            bus_len = pb_n + RLW'(2);
        end else begin
            bus_rsp        = '0;
            bus_rsp[23:0]  = {first_b, pb_status, PT_BUS};
            bus_len        = RLW'(3);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_len     <= '0;
            rsp_data    <= '0;
            pb_req      <= 1'b0;
            pb_req_len  <= '0;
            pb_req_data <= '0;
            first_b     <= 8'd0;
            wait_pb     <= 1'b0;
        end else begin
            rsp_valid <= is_cmd || bus_fire;
            pb_req    <= is_bus;
            if (is_cmd) begin
                rsp_data <= cmd_rsp;
                rsp_len  <= cmd_len;
            end else if (bus_fire) begin
                rsp_data <= bus_rsp;
                rsp_len  <= bus_len;
            end
            if (is_bus) begin
                pb_req_data <= pkt_data[MAX_PKT*8-1:8];
                pb_req_len  <= pkt_len - LW'(1);
                first_b     <= pkt_data[15:8];
                wait_pb     <= 1'b1;
            end else if (bus_fire) begin
                wait_pb     <= 1'b0;
            end
        end
    end

    // R4 R5
    err_len_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_data[7:0] == PT_ERR) |-> (rsp_len == RLW'(4)));

    // R12
    pb_excl_chk: assert property (@(posedge clk) disable iff (rst)
        pb_req |-> !rsp_valid);

    // R10
    pulse_reply_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_down_req || sys_reset_req) |-> (rsp_valid && rsp_data[7:0] == PT_CMD && rsp_len == RLW'(3)));

    // R2
    reply_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(pkt_valid || pb_done));

endmodule

// File: tb/test_pkt_dispatch.sv
module test_pkt_dispatch;

    localparam int LW  = 4;
    localparam int RLW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid = 1'b0;
    logic [LW-1:0] pkt_len = '0;
    logic [63:0] pkt_data = '0;
    logic        sec_tick = 1'b0;
    logic        rsp_valid;
    logic [RLW-1:0] rsp_len;
    logic [63:0] rsp_data;
    logic        pb_req;
    logic [LW-1:0] pb_req_len;
    logic [55:0] pb_req_data;
    logic        pb_done = 1'b0;
    logic [7:0]  pb_status = 8'd0;
    logic [RLW-1:0] pb_rsp_len = '0;
    logic [47:0] pb_rsp_data = '0;
    logic [15:0] poll_mask;
    logic        autopoll_en;
    logic [7:0]  poll_rate;
    logic        pwr_down_req, sys_reset_req;

    always #10 clk = ~clk;

    pkt_dispatch i_pkt_dispatch (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_data(pkt_data),
        .sec_tick(sec_tick), .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_data(rsp_data),
        .pb_req(pb_req), .pb_req_len(pb_req_len), .pb_req_data(pb_req_data),
        .pb_done(pb_done), .pb_status(pb_status), .pb_rsp_len(pb_rsp_len),
        .pb_rsp_data(pb_rsp_data), .poll_mask(poll_mask), .autopoll_en(autopoll_en),
        .poll_rate(poll_rate), .pwr_down_req(pwr_down_req), .sys_reset_req(sys_reset_req)
    );

    localparam logic [7:0] C_AUTO = 8'h01, C_RATE = 8'h14, C_MASK = 8'h19, C_PWRDN = 8'h0A,
                           C_RST = 8'h11, C_FSF = 8'h13, C_PMSG = 8'h21, C_GET = 8'h03,
                           C_SET = 8'h09;

    typedef struct {
        logic [63:0] d;
        int          len;
        bit          pd;
        bit          sr;
        string       req;
    } exp_t;

    exp_t q[$];
    int   vectors = 0;
    int   miscompares = 0;
    bit   finished = 1'b0;
    bit   pb_expect = 1'b0;

    function automatic logic [63:0] mk(input logic [7:0] a0, input logic [7:0] a1 = 0,
        input logic [7:0] a2 = 0, input logic [7:0] a3 = 0, input logic [7:0] a4 = 0,
        input logic [7:0] a5 = 0, input logic [7:0] a6 = 0, input logic [7:0] a7 = 0);
        return {a7, a6, a5, a4, a3, a2, a1, a0};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a reply appears
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (rsp_valid) begin
                if (q.size() == 0) begin
                    vectors++; miscompares++;
                    $display("FAIL R2: actual unexpected reply %h len %0d expected none", rsp_data, rsp_len);
                end else begin
                    exp_t e;
                    logic [63:0] m;
                    e = q.pop_front();
                    m = '0;
                    for (int i = 0; i < 8; i++) if (i < e.len) m[8*i +: 8] = 8'hFF;
                    chk({e.req, " reply length"}, 64'(rsp_len), 64'(e.len));
                    chk({e.req, " reply bytes"}, rsp_data & m, e.d & m);
                    chk({e.req, " power-down pulse"}, 64'(pwr_down_req), 64'(e.pd));
                    chk({e.req, " reset pulse"}, 64'(sys_reset_req), 64'(e.sr));
                end
            end else if (pwr_down_req || sys_reset_req) begin
                vectors++; miscompares++;
                $display("FAIL R10: actual stray request pulse pd=%0b sr=%0b expected none",
                         pwr_down_req, sys_reset_req);
            end
            if (pb_req && !pb_expect) begin
                vectors++; miscompares++;
                $display("FAIL R2: actual stray pb_req expected none");
            end
        end
    end

    task automatic send(input logic [63:0] d, input int len, input bit has_rsp,
                        input logic [63:0] ed, input int elen, input bit epd, input bit esr,
                        input string req, input bit tick = 1'b0);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_len = LW'(len); pkt_data = d; sec_tick = tick;
        if (has_rsp) begin
            exp_t e;
            e.d = ed; e.len = elen; e.pd = epd; e.sr = esr; e.req = req;
            q.push_back(e);
        end
        @(negedge clk);
        pkt_valid = 1'b0; sec_tick = 1'b0;
        if (!has_rsp) chk({req, " no reply"}, 64'({rsp_valid, pb_req}), 64'd0);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic get_time(input logic [31:0] t, input string req);
        send(mk(8'd1, C_GET), 2, 1'b1,
             mk(8'd1, 8'd0, C_GET, t[31:24], t[23:16], t[15:8], t[7:0]), 7, 1'b0, 1'b0, req);
    endtask

    task automatic ack(input logic [63:0] d, input int len, input logic [7:0] c, input string req,
                       input bit pd = 1'b0, input bit sr = 1'b0);
        send(d, len, 1'b1, mk(8'd1, 8'd0, c), 3, pd, sr, req);
    endtask

    task automatic bad(input logic [63:0] d, input int len, input logic [7:0] c, input string req);
        send(d, len, 1'b1, mk(8'd2, 8'd5, 8'd1, c), 4, 1'b0, 1'b0, req);
    endtask

    task automatic bus_xact(input logic [63:0] d, input int len, input logic [7:0] st,
                            input logic [47:0] rdata, input int rlen,
                            input logic [63:0] ed, input int elen, input string req);
        pb_expect = 1'b1;
        @(negedge clk);
        pkt_valid = 1'b1; pkt_len = LW'(len); pkt_data = d;
        @(negedge clk);
        pkt_valid = 1'b0;
        chk({req, " pb_req"}, 64'(pb_req), 64'd1);
        chk({req, " pb_req_len"}, 64'(pb_req_len), 64'(len - 1));
        chk({req, " pb_req_data"}, 64'(pb_req_data) & ((64'd1 << (8*(len-1))) - 1),
            (d >> 8) & ((64'd1 << (8*(len-1))) - 1));
        @(negedge clk);
        pb_done = 1'b1; pb_status = st; pb_rsp_data = rdata; pb_rsp_len = RLW'(rlen);
        begin
            exp_t e;
            e.d = ed; e.len = elen; e.pd = 1'b0; e.sr = 1'b0; e.req = req;
            q.push_back(e);
        end
        @(negedge clk);
        pb_done = 1'b0;
        @(negedge clk);
        pb_expect = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 poll_mask", 64'(poll_mask), 64'hFFFF);
        chk("R1 autopoll_en", 64'(autopoll_en), 64'd0);
        chk("R1 poll_rate", 64'(poll_rate), 64'd20);
        chk("R1 rsp_valid/pb_req", 64'({rsp_valid, pb_req}), 64'd0);
        get_time(32'd0, "R1 seconds at reset");

        // R9 counter, load, load-over-tick, wrap
        ticks(3);
        get_time(32'd3, "R9 after three ticks");
        ack(mk(8'd1, C_SET, 8'h12, 8'h34, 8'h56, 8'h78), 6, C_SET, "R9 set time");
        get_time(32'h12345678, "R9 read after set");
        send(mk(8'd1, C_SET, 8'hAA, 8'hBB, 8'hCC, 8'hDD), 6, 1'b1, mk(8'd1, 8'd0, C_SET), 3,
             1'b0, 1'b0, "R9 set with tick", 1'b1);
        get_time(32'hAABBCCDD, "R9 load wins over tick");
        ack(mk(8'd1, C_SET, 8'hFF, 8'hFF, 8'hFF, 8'hFF), 6, C_SET, "R9 set all ones");
        ticks(1);
        get_time(32'd0, "R9 wrap");
        bad(mk(8'd1, C_SET, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05), 7, C_SET, "R5 set time five params");
        get_time(32'd0, "R5 time unchanged after bad set");
        bad(mk(8'd1, C_GET, 8'h00), 3, C_GET, "R5 read time with param");

        // R8 autopoll
        ack(mk(8'd1, C_AUTO, 8'h05), 3, C_AUTO, "R8 autopoll on");
        chk("R8 autopoll enabled", 64'(autopoll_en), 64'd1);
        bad(mk(8'd1, C_AUTO, 8'h00, 8'h00), 4, C_AUTO, "R5 autopoll two params");
        chk("R5 autopoll unchanged", 64'(autopoll_en), 64'd1);
        ack(mk(8'd1, C_AUTO, 8'h00), 3, C_AUTO, "R8 autopoll off");
        chk("R8 autopoll disabled", 64'(autopoll_en), 64'd0);

        // R6 poll rate
        bad(mk(8'd1, C_RATE, 8'h00), 3, C_RATE, "R6 rate zero");
        chk("R6 rate kept", 64'(poll_rate), 64'd20);
        ack(mk(8'd1, C_RATE, 8'h07), 3, C_RATE, "R6 rate seven");
        chk("R6 rate loaded", 64'(poll_rate), 64'd7);
        bad(mk(8'd1, C_RATE), 2, C_RATE, "R5 rate no param");

        // R7 mask
        ack(mk(8'd1, C_MASK, 8'h12, 8'h34), 4, C_MASK, "R7 mask");
        chk("R7 mask big-endian", 64'(poll_mask), 64'h1234);
        bad(mk(8'd1, C_MASK, 8'h55), 3, C_MASK, "R5 mask one param");
        bad(mk(8'd1, C_MASK, 8'h55, 8'h66, 8'h77), 5, C_MASK, "R5 mask three params");
        chk("R5 mask unchanged", 64'(poll_mask), 64'h1234);

        // R10 requests
        ack(mk(8'd1, C_PWRDN), 2, C_PWRDN, "R10 power-down", 1'b1, 1'b0);
        bad(mk(8'd1, C_PWRDN, 8'h00), 3, C_PWRDN, "R10 power-down with param");
        ack(mk(8'd1, C_RST), 2, C_RST, "R10 system reset", 1'b0, 1'b1);
        bad(mk(8'd1, C_RST, 8'h01), 3, C_RST, "R10 reset with param");

        // R11 no-effect commands
        ack(mk(8'd1, C_FSF, 8'h01), 3, C_FSF, "R11 file-server flag");
        ack(mk(8'd1, C_PMSG, 8'h01), 3, C_PMSG, "R11 power messages");
        chk("R11 registers untouched", {40'd0, poll_mask, autopoll_en, poll_rate[6:0]},
            {40'd0, 16'h1234, 1'b0, 7'd7});
        bad(mk(8'd1, C_FSF), 2, C_FSF, "R5 file-server flag no param");

        // R4 unknown code, R3 reply format
        send(mk(8'd1, 8'h55), 2, 1'b1, mk(8'd2, 8'd2, 8'd1, 8'h55), 4, 1'b0, 1'b0, "R4 unknown code");
        send(mk(8'd1, 8'hFE, 8'h01), 3, 1'b1, mk(8'd2, 8'd2, 8'd1, 8'hFE), 4, 1'b0, 1'b0, "R4 unknown with param");
        ack(mk(8'd1, C_FSF, 8'h00), 3, C_FSF, "R3 success reply shape");

        // R2 ignored packet types
        for (int t = 2; t <= 6; t++)
            send(mk(8'(t), C_RATE, 8'h09), 3, 1'b0, '0, 0, 1'b0, 1'b0, "R2 ignored type");
        send(mk(8'd1), 1, 1'b0, '0, 0, 1'b0, 1'b0, "R2 short command packet");
        send(mk(8'd9, C_MASK, 8'h00, 8'h00), 4, 1'b0, '0, 0, 1'b0, 1'b0, "R2 type nine");
        chk("R2 state untouched", {47'd0, poll_mask, poll_rate[0]}, {47'd0, 16'h1234, 1'b1});
        chk("R2 rate untouched", 64'(poll_rate), 64'd7);

        // R12 peripheral bus
        bus_xact(mk(8'd0, 8'h2C, 8'hAA), 3, 8'd0, 48'h2211, 2,
                 mk(8'd0, 8'd0, 8'h11, 8'h22), 4, "R12 bus success");
        bus_xact(mk(8'd0, 8'h3C), 2, 8'd3, 48'h0, 0,
                 mk(8'd0, 8'd3, 8'h3C), 3, "R12 bus error");
        bus_xact(mk(8'd0, 8'h4D, 8'h01, 8'h02, 8'h03), 5, 8'd0, 48'h060504030201, 6,
                 mk(8'd0, 8'd0, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06), 8, "R12 bus long answer");

        repeat (4) @(negedge clk);
        chk("scoreboard drained", 64'(q.size()), 64'd0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++; miscompares++;
            $display("FAIL watchdog: actual run still going expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule